// File: doc/BRIEF.md
# Inverting GPIO Port

This block is one general-purpose I/O port of up to eight pins. Its registers sit behind a banked configuration interface. A logical device number on `dev_sel` selects the bank, and an 8-bit index selects the register inside it. The device bank holds the port's direction, data and inversion registers, plus a control register that contains the port's enable bit. The output driver mode bit lives in a global register, which can be reached whatever bank is selected.

Every pin has a polarity inversion bit. This bit affects both directions of the pin. The level driven onto an output pin is the stored data bit XOR the inversion bit. A read of an input pin returns the synchronized pad level XOR the inversion bit. The port-wide driver mode decides how a driven high reaches the pad. In push-pull mode the pad is actively driven high. In open-drain mode the pad is released, so the output enable is off.

The pin count is a parameter. A port with fewer than eight pins stores nothing above its pin count, and those bits read as zero. Register reads are combinational from the index. Register writes take effect on the next clock edge.

Top module: `gpx_port`

## Requirements
- R1: After reset, the direction register reads all ones in the implemented bits (every pin is an input). The data, inversion, enable and mode bits read 0 (open-drain), and every `pin_oe` bit is 0.
- R2: The device registers are decoded only when `dev_sel` equals `DEV_ID`. They sit at these indices, with base = 0xE0 + 4*`PORT_SLOT`:
  - direction at base
  - data at base+1
  - inversion at base+2
  - control at `EN_IDX`

  A write with another `dev_sel`, or to another slot's indices, changes nothing.
- R3: Direction bit 1 makes a pin an input, and its `pin_oe` is 0. Direction bit 0 makes it an output.
- R4: In push-pull mode, an output pin of an enabled port has `pin_oe`=1 and `pin_out` = data XOR inversion.
- R5: In open-drain mode, `pin_out` is 0 for every pin. An output pin of an enabled port whose data XOR inversion is 0 has `pin_oe`=1. When that value is 1, `pin_oe`=0.
- R6: The driver mode is bit `MODE_BIT` of the global register at index `MODE_IDX`, with 1 = push-pull and 0 = open-drain. This register is reachable under any `dev_sel`, and its other bits read 0.
- R7: The port enable is bit `EN_BIT` of the control register, and the control register's other bits read 0. While the enable bit is 0, every `pin_oe` bit is 0.
- R8: A read of the data register returns two kinds of bits:
  - for input pins, the pad level XOR the inversion bit, where the pad level passes through a two-flop synchronizer and is visible two clock edges after it changes;
  - for output pins, the stored data bit.
- R9: Bits at and above `PIN_COUNT` in the direction, data and inversion registers are not stored, and they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 8 | Selected logical device (bank) |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_out | output | PIN_COUNT | Pad output levels |
| pin_oe | output | PIN_COUNT | Pad output enables |

## Verification
The hardest case to reach is a data-register read that combines three sources at once. Input bits must come from the synchronized pads with inversion applied, while output bits come from the stored data. The bench reaches this by setting a mixed direction pattern and a nonzero inversion mask. It then changes `pin_in`, waits exactly two edges, and reads the data register. The open-drain release case needs the port enabled, a pin set to output, and data XOR inversion equal to 1 together. A full sweep of data against inversion in both driver modes covers every such combination on the five-pin configuration.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_DATA,
        SEL_INV,
        SEL_CTRL,
        SEL_MODE
    } sel_e;

    typedef struct packed {
        byte_t dir;
        byte_t data;
        byte_t inv;
    } port_regs_t;

    function automatic byte_t pin_mask(input int n);
        return byte_t'((9'd1 << n) - 9'd1);
    endfunction

    function automatic sel_e decode_sel(
        input byte_t addr,
        input byte_t dev,
        input byte_t dev_id,
        input byte_t base,
        input byte_t ctrl_idx,
        input byte_t mode_idx
    );
        sel_e s;
        s = SEL_NONE;
        if (addr == mode_idx) begin
            s = SEL_MODE;
        end else if (dev == dev_id) begin
            if (addr == ctrl_idx)          s = SEL_CTRL;
            else if (addr == base)         s = SEL_DIR;
            else if (addr == base + 8'd1)  s = SEL_DATA;
            else if (addr == base + 8'd2)  s = SEL_INV;
        end
        return s;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int    PIN_COUNT = 8,
    parameter byte_t DEV_ID    = 8'h09,
    parameter int    PORT_SLOT = 0,
    parameter byte_t EN_IDX    = 8'h30,
    parameter int    EN_BIT    = 0,
    parameter byte_t MODE_IDX  = 8'h2C,
    parameter int    MODE_BIT  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  byte_t      dev_sel,
    input  byte_t      reg_addr,
    input  byte_t      reg_wdata,
    input  logic       reg_we,
    input  byte_t      pad_sync,
    output port_regs_t regs,
    output logic       port_en,
    output logic       push_pull,
    output byte_t      reg_rdata
);
    localparam byte_t MASK = pin_mask(PIN_COUNT);
    localparam byte_t BASE = 8'hE0 + byte_t'(4 * PORT_SLOT);

    port_regs_t regs_q;
    logic       en_q;
    logic       mode_q;
    sel_e       sel;

    assign sel = decode_sel(reg_addr, dev_sel, DEV_ID, BASE, EN_IDX, MODE_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.dir  <= MASK;
            regs_q.data <= '0;
            regs_q.inv  <= '0;
            en_q        <= 1'b0;
            mode_q      <= 1'b0;
        end else if (reg_we) begin
            case (sel)
                SEL_DIR:  regs_q.dir  <= reg_wdata & MASK;
                SEL_DATA: regs_q.data <= reg_wdata & MASK;
                SEL_INV:  regs_q.inv  <= reg_wdata & MASK;
                SEL_CTRL: en_q        <= reg_wdata[EN_BIT];
                SEL_MODE: mode_q      <= reg_wdata[MODE_BIT];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_DIR:  reg_rdata = regs_q.dir;
            SEL_DATA: reg_rdata = (((pad_sync & MASK) ^ regs_q.inv) & regs_q.dir)
                                | (regs_q.data & ~regs_q.dir);
            SEL_INV:  reg_rdata = regs_q.inv;
            SEL_CTRL: reg_rdata = byte_t'({7'd0, en_q}) << EN_BIT;
            SEL_MODE: reg_rdata = byte_t'({7'd0, mode_q}) << MODE_BIT;
            default:  reg_rdata = '0;
        endcase
    end

    assign regs      = regs_q;
    assign port_en   = en_q;
    assign push_pull = mode_q;

    AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs_q.dir == MASK && !en_q && !mode_q)); // R1

    AST_FOREIGN_BANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && dev_sel != DEV_ID && reg_addr != MODE_IDX)
        |=> ($stable(regs_q) && $stable(en_q))); // R2
endmodule

// File: rtl/gpx_drive.sv
module gpx_drive #(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_COUNT-1:0] dir,
    input  logic [PIN_COUNT-1:0] data,
    input  logic [PIN_COUNT-1:0] inv,
    input  logic                 port_en,
    input  logic                 push_pull,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        logic level;
        logic active;
        assign level      = data[i] ^ inv[i];
        assign active     = port_en & ~dir[i];
        assign pin_out[i] = push_pull & level;
        assign pin_oe[i]  = active & (push_pull | ~level);
    end

    AST_DISABLED_NO_OE: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> (pin_oe == '0)); // R7

    AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & dir) == '0)); // R3

    AST_OD_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        !push_pull |-> (pin_out == '0)); // R5
endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int    PIN_COUNT = 8,
    parameter byte_t DEV_ID    = 8'h09,
    parameter int    PORT_SLOT = 0,
    parameter byte_t EN_IDX    = 8'h30,
    parameter int    EN_BIT    = 0,
    parameter byte_t MODE_IDX  = 8'h2C,
    parameter int    MODE_BIT  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           dev_sel,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_we,
    output logic [7:0]           reg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    logic [PIN_COUNT-1:0] pad_sync;
    byte_t                pad_ext;
    port_regs_t           regs;
    logic                 port_en;
    logic                 push_pull;

    gpx_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pad_sync)
    );

    assign pad_ext = byte_t'(pad_sync);

    gpx_regs #(
        .PIN_COUNT (PIN_COUNT),
        .DEV_ID    (DEV_ID),
        .PORT_SLOT (PORT_SLOT),
        .EN_IDX    (EN_IDX),
        .EN_BIT    (EN_BIT),
        .MODE_IDX  (MODE_IDX),
        .MODE_BIT  (MODE_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .dev_sel   (dev_sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .pad_sync  (pad_ext),
        .regs      (regs),
        .port_en   (port_en),
        .push_pull (push_pull),
        .reg_rdata (reg_rdata)
    );

    gpx_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .dir       (regs.dir[PIN_COUNT-1:0]),
        .data      (regs.data[PIN_COUNT-1:0]),
        .inv       (regs.inv[PIN_COUNT-1:0]),
        .port_en   (port_en),
        .push_pull (push_pull),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );
endmodule

// File: tb/sim_gpx_port.sv
`timescale 1ns/1ps
module sim_gpx_port;
    localparam int       NP   = 5;
    localparam logic [7:0] DEV  = 8'h08;
    localparam logic [7:0] BASE = 8'hE4;
    localparam logic [7:0] CTRL = 8'h30;
    localparam logic [7:0] MIDX = 8'h29;
    localparam logic [7:0] MSK  = 8'h1F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    dev_sel = 8'h00;
    logic [7:0]    reg_addr = 8'h00;
    logic [7:0]    reg_wdata = 8'h00;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpx_port #(
        .PIN_COUNT (NP),
        .DEV_ID    (DEV),
        .PORT_SLOT (1),
        .EN_IDX    (CTRL),
        .EN_BIT    (2),
        .MODE_IDX  (MIDX),
        .MODE_BIT  (7)
    ) u0 (
        .clk, .rst, .dev_sel, .reg_addr, .reg_wdata, .reg_we,
        .reg_rdata, .pin_in, .pin_out, .pin_oe
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] dv, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dev_sel = dv; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        #0.5;
    endtask

    task automatic rd(input logic [7:0] dv, input logic [7:0] a, output logic [7:0] v);
        dev_sel = dv; reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #0.5;

        // R1 reset state
        rd(DEV, BASE, v);        chk("R1 dir", v, MSK);
        rd(DEV, BASE + 1, v);    chk("R1 data", v, 8'h00);
        rd(DEV, BASE + 2, v);    chk("R1 inv", v, 8'h00);
        rd(DEV, CTRL, v);        chk("R1 ctrl", v, 8'h00);
        rd(8'h00, MIDX, v);      chk("R1 mode", v, 8'h00);
        chk("R1 oe", 8'(pin_oe), 8'h00);

        // R2 foreign bank and other slot are ignored
        wr(8'h07, BASE, 8'h00);
        rd(DEV, BASE, v);        chk("R2 other bank", v, MSK);
        wr(DEV, 8'hE0, 8'h00);
        rd(DEV, BASE, v);        chk("R2 other slot", v, MSK);
        wr(8'h07, CTRL, 8'hFF);
        rd(DEV, CTRL, v);        chk("R2 ctrl other bank", v, 8'h00);

        // R7 control register holds only the enable bit
        wr(DEV, CTRL, 8'hFF);
        rd(DEV, CTRL, v);        chk("R7 ctrl bits", v, 8'h04);

        // R6 mode register from any bank, other bits zero
        wr(8'h55, MIDX, 8'hFF);
        rd(8'h02, MIDX, v);      chk("R6 mode pp", v, 8'h80);

        // R4 push-pull sweep over data x inversion, all outputs
        wr(DEV, BASE, 8'h00);
        for (int d = 0; d < 32; d++) begin
            for (int i = 0; i < 32; i++) begin
                wr(DEV, BASE + 2, 8'(i));
                wr(DEV, BASE + 1, 8'(d));
                chk("R4 oe", 8'(pin_oe), MSK);
                chk("R4 out", 8'(pin_out), 8'(d ^ i));
            end
        end

        // R5 open-drain sweep
        wr(DEV, MIDX, 8'h00);
        rd(DEV, MIDX, v);        chk("R6 mode od", v, 8'h00);
        for (int d = 0; d < 32; d++) begin
            for (int i = 0; i < 32; i++) begin
                wr(DEV, BASE + 2, 8'(i));
                wr(DEV, BASE + 1, 8'(d));
                chk("R5 oe", 8'(pin_oe), 8'(~(d ^ i)) & MSK);
                chk("R5 out", 8'(pin_out), 8'h00);
            end
        end

        // R3 direction sweep in push-pull
        wr(DEV, MIDX, 8'h80);
        wr(DEV, BASE + 1, 8'h15);
        wr(DEV, BASE + 2, 8'h03);
        for (int dr = 0; dr < 32; dr++) begin
            wr(DEV, BASE, 8'(dr));
            chk("R3 oe", 8'(pin_oe), 8'(~dr) & MSK);
            rd(DEV, BASE, v);    chk("R3 dir readback", v, 8'(dr));
        end

        // R8 input read path with synchronizer latency and inversion
        wr(DEV, BASE, 8'h1F);
        wr(DEV, BASE + 2, 8'h0A);
        for (int p = 0; p < 32; p++) begin
            pin_in = NP'(p);
            @(negedge clk);
            @(negedge clk); #0.5;
            rd(DEV, BASE + 1, v); chk("R8 input read", v, 8'(p ^ 8'h0A));
        end
        // mixed direction: pins 2,3 input, others output
        wr(DEV, BASE, 8'h0C);
        wr(DEV, BASE + 1, 8'h13);
        for (int p = 0; p < 32; p++) begin
            pin_in = NP'(p);
            @(negedge clk);
            @(negedge clk); #0.5;
            rd(DEV, BASE + 1, v);
            chk("R8 mixed read", v, ((8'(p) ^ 8'h0A) & 8'h0C) | (8'h13 & 8'h13));
        end

        // R7 disabled port drives nothing
        wr(DEV, BASE, 8'h00);
        wr(DEV, CTRL, 8'h00);
        chk("R7 disabled oe", 8'(pin_oe), 8'h00);
        wr(DEV, CTRL, 8'h04);
        chk("R7 reenabled oe", 8'(pin_oe), MSK);

        // R9 bits above pin count not stored
        wr(DEV, BASE, 8'hFF);
        rd(DEV, BASE, v);        chk("R9 dir upper", v, MSK);
        wr(DEV, BASE + 2, 8'hE0);
        rd(DEV, BASE + 2, v);    chk("R9 inv upper", v, 8'h00);
        wr(DEV, BASE, 8'h00);
        wr(DEV, BASE + 1, 8'hE0);
        rd(DEV, BASE + 1, v);    chk("R9 data upper", v, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule